// File: doc/BRIEF.md
# Load/Store Pair Micro-op Cracker

This block sits in a decode stage and turns one 32-bit paired load or paired store instruction into two single-register memory micro-ops. The first micro-op moves the first register of the pair. The second moves the second register, at an address one element further on. The upstream stage holds the instruction on a valid/ready input until the block has handed out the final micro-op. Each micro-op goes out on its own valid/ready handshake.

The block reads the base register through a combinational read port: it drives the index and gets the value back in the same cycle. It computes the effective address of each micro-op. For pre-indexed and post-indexed forms, the base-register update travels with the second micro-op only. Its value is that micro-op's own address plus a constant that removes the element step again. An encoding the block cannot crack becomes a single micro-op that carries an illegal flag.

Top module: `ldst_pair_cracker`

## Requirements
- R1: `inInstr` is a crackable pair only when bits [29:27] are 3'b101, bit 25 is 0 and the vector bit 26 is 0. Any other pattern, vector forms included, raises `outIllegal`.
- R2: The field opc is `inInstr[31:30]` and bit 22 set marks a load. Addressing mode bits [24:23] mean: 01 post-index, 11 pre-index, 10 or 00 plain offset. An encoding is illegal when opc is 3, or when it is a store with opc[0] set, or when it is a load with opc[0] set in a plain-offset mode.
- R3: An illegal instruction produces exactly one micro-op, with `outIllegal`=1, `outLast`=1, `outUopIdx`=0, `outWbEn`=0 and `outDestWrite`=0. The input is consumed (`inReady`=1) on that micro-op's acceptance.
- R4: A legal instruction produces micro-op 0 with `outLast`=0, then micro-op 1 with `outLast`=1. `inReady` is high only in the cycle where micro-op 1 is accepted.
- R5: `outSizeLog2` is 2 + opc[1], giving 4- or 8-byte elements. `outSigned` is 1 only for a load with opc[0] set.
- R6: The scaled offset is imm7 (`inInstr[21:15]`, signed) shifted left by `outSizeLog2`. Micro-op 0's address is base plus the scaled offset, where base is `baseData` read at index `baseIdx` = `inInstr[9:5]`. Micro-op 1's address is micro-op 0's address plus the element size. In post-index mode the offset term is zero.
- R7: `outWbEn` is 1 only on micro-op 1 of a pre- or post-indexed form. There `outWbReg` = rn, and `outWbData` = micro-op 1's address plus (imm - element size) for post-index, or plus (-element size) for pre-index. Both work out to base + scaled offset.
- R8: `outReg` is rt (`inInstr[4:0]`) on micro-op 0 and rt2 (`inInstr[14:10]`) on micro-op 1. `outDestWrite` is 1 only for a legal load whose `outReg` is not 31. A load to register 31 still issues its access.
- R9: While `outValid` is high and `outReady` is low, the micro-op index and all outputs hold.
- R10: All address sums wrap modulo 2^ADDR_W.
- R11: Reset returns the sequencer to micro-op 0, including in the middle of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Instruction consumed this cycle |
| inInstr | input | 32 | Fetched instruction word |
| baseIdx | output | 5 | Base register read index |
| baseData | input | ADDR_W | Base register value |
| outValid | output | 1 | Micro-op present |
| outReady | input | 1 | Micro-op accepted |
| outIsLoad | output | 1 | Micro-op is a load |
| outSizeLog2 | output | 2 | log2 of access bytes |
| outSigned | output | 1 | Sign-extend loaded element |
| outReg | output | 5 | Data register index |
| outDestWrite | output | 1 | Load writes outReg |
| outAddr | output | ADDR_W | Effective address |
| outWbEn | output | 1 | Base writeback present |
| outWbReg | output | 5 | Base register to update |
| outWbData | output | ADDR_W | Base writeback value |
| outUopIdx | output | 1 | Micro-op index, 0 or 1 |
| outLast | output | 1 | Final micro-op of instruction |
| outIllegal | output | 1 | Unallocated or uncrackable encoding |

## Verification
The bench builds the block with its default ADDR_W of 64. At that width a base near the top of the address space shows the second micro-op's address wrapping to zero. Negative immediates exercise both 4-byte and 8-byte scaling, and the compensating writeback constant can be compared against the plain base-plus-offset result. The vector table covers every opc and mode combination that matters for legality, and signed pair loads in both legal and illegal modes.

// File: rtl/ldst_pair_cracker_pkg.sv
package ldst_pair_cracker_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam logic [REG_W-1:0] ZERO_REG = 5'd31;

  typedef enum logic [1:0] {
    MODE_NOALLOC = 2'b00,
    MODE_POST    = 2'b01,
    MODE_OFFSET  = 2'b10,
    MODE_PRE     = 2'b11
  } idxMode_e;

  typedef struct packed {
    logic secondUop;
    logic finalUop;
  } crackStrobe_t;
endpackage

// File: rtl/ldst_pair_ctrl.sv
module ldst_pair_ctrl
  import ldst_pair_cracker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         illegal,
  output logic         outValid,
  output logic         inReady,
  output crackStrobe_t strobe
);
  logic uopIdx;
  logic fire;

  assign outValid         = inValid;
  assign strobe.secondUop = uopIdx;
  assign strobe.finalUop  = uopIdx | illegal;
  assign fire             = outValid & outReady;
  assign inReady          = fire & strobe.finalUop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uopIdx <= 1'b0;
    end else if (fire) begin
      uopIdx <= ~strobe.finalUop;
    end
  end
endmodule

// File: rtl/ldst_pair_dp.sv
module ldst_pair_dp
  import ldst_pair_cracker_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  baseData,
  input  crackStrobe_t       strobe,
  output logic [REG_W-1:0]   baseIdx,
  output logic               illegal,
  output logic               isLoad,
  output logic [1:0]         sizeLog2,
  output logic               signedLd,
  output logic [REG_W-1:0]   dataReg,
  output logic               destWrite,
  output logic [ADDR_W-1:0]  addr,
  output logic               wbEn,
  output logic [REG_W-1:0]   wbReg,
  output logic [ADDR_W-1:0]  wbData
);
  localparam int IMM_W = 7;

  logic [1:0]        opc;
  idxMode_e          mode;
  logic [IMM_W-1:0]  imm7;
  logic              pairClass;
  logic              isPost, isPre;
  logic [ADDR_W-1:0] immExt, immScaled, eltBytes, offAddr, wbConst;

  assign opc       = instr[31:30];
  assign mode      = idxMode_e'(instr[24:23]);
  assign isLoad    = instr[22];
  assign imm7      = instr[21:15];
  assign baseIdx   = instr[9:5];
  assign wbReg     = instr[9:5];
  assign isPost    = (mode == MODE_POST);
  assign isPre     = (mode == MODE_PRE);
  assign pairClass = (instr[29:27] == 3'b101) && !instr[25] && !instr[26];

  always_comb begin
    illegal = !pairClass || (opc == 2'b11);
    if (!isLoad && opc[0]) illegal = 1'b1;
    if (isLoad && opc[0] && !(isPost || isPre)) illegal = 1'b1;
  end

  assign sizeLog2 = {1'b1, opc[1]};
  assign signedLd = isLoad & opc[0];

  assign immExt    = {{(ADDR_W-IMM_W){imm7[IMM_W-1]}}, imm7};
  assign immScaled = opc[1] ? (immExt << 3) : (immExt << 2);
  assign eltBytes  = opc[1] ? ADDR_W'(8) : ADDR_W'(4);

  assign offAddr = baseData + (isPost ? '0 : immScaled);
  assign addr    = offAddr + (strobe.secondUop ? eltBytes : '0);
  assign wbConst = isPost ? (immScaled - eltBytes) : (ADDR_W'(0) - eltBytes);
  assign wbData  = addr + wbConst;

  assign wbEn      = !illegal && strobe.secondUop && (isPost || isPre);
  assign dataReg   = strobe.secondUop ? instr[14:10] : instr[4:0];
  assign destWrite = !illegal && isLoad && (dataReg != ZERO_REG);
endmodule

// File: rtl/ldst_pair_cracker.sv
module ldst_pair_cracker
  import ldst_pair_cracker_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [31:0]       inInstr,
  output logic [4:0]        baseIdx,
  input  logic [ADDR_W-1:0] baseData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsLoad,
  output logic [1:0]        outSizeLog2,
  output logic              outSigned,
  output logic [4:0]        outReg,
  output logic              outDestWrite,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outWbEn,
  output logic [4:0]        outWbReg,
  output logic [ADDR_W-1:0] outWbData,
  output logic              outUopIdx,
  output logic              outLast,
  output logic              outIllegal
);
  crackStrobe_t strobe;
  logic         illegal;

  ldst_pair_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .illegal  (illegal),
    .outValid (outValid),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  ldst_pair_dp #(.ADDR_W(ADDR_W)) u_dp (
    .instr     (inInstr),
    .baseData  (baseData),
    .strobe    (strobe),
    .baseIdx   (baseIdx),
    .illegal   (illegal),
    .isLoad    (outIsLoad),
    .sizeLog2  (outSizeLog2),
    .signedLd  (outSigned),
    .dataReg   (outReg),
    .destWrite (outDestWrite),
    .addr      (outAddr),
    .wbEn      (outWbEn),
    .wbReg     (outWbReg),
    .wbData    (outWbData)
  );

  assign outUopIdx  = strobe.secondUop;
  assign outLast    = strobe.finalUop;
  assign outIllegal = illegal;
endmodule

// File: rtl/ldst_pair_cracker_chk.sv
module ldst_pair_cracker_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [31:0]       inInstr,
  input logic [4:0]        baseIdx,
  input logic [ADDR_W-1:0] baseData,
  input logic              outValid,
  input logic              outReady,
  input logic              outIsLoad,
  input logic [1:0]        outSizeLog2,
  input logic              outSigned,
  input logic [4:0]        outReg,
  input logic              outDestWrite,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outWbEn,
  input logic [4:0]        outWbReg,
  input logic [ADDR_W-1:0] outWbData,
  input logic              outUopIdx,
  input logic              outLast,
  input logic              outIllegal
);
  // R3
  illegal_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIllegal) |-> (outLast && !outUopIdx && !outWbEn && !outDestWrite));

  // R4
  consume_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (outValid && outReady && outLast));

  // R4
  second_follows_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> (outUopIdx && outLast));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=>
      (outAddr == $past(outAddr) + (ADDR_W'(1) << outSizeLog2)));

  // R7
  wb_second_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWbEn |-> (outUopIdx && !outIllegal));

  // R8
  dest_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDestWrite |-> (outIsLoad && outReg != 5'd31));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outUopIdx));
endmodule

bind ldst_pair_cracker ldst_pair_cracker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ldst_pair_cracker_tb.sv
module ldst_pair_cracker_tb;
  localparam int AW = 64;
  localparam realtime HALF = 4ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [31:0] inInstr = '0;
  logic [AW-1:0] baseData = '0;
  logic inReady, outValid, outIsLoad, outSigned, outDestWrite, outWbEn;
  logic outUopIdx, outLast, outIllegal;
  logic [4:0] baseIdx, outReg, outWbReg;
  logic [1:0] outSizeLog2;
  logic [AW-1:0] outAddr, outWbData;

  always #HALF clk = ~clk;

  ldst_pair_cracker #(.ADDR_W(AW)) u_dut (.*);

  int nChecks = 0, nBad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  opc;
    logic        vec;
    logic [1:0]  mode;
    logic        ld;
    logic [6:0]  imm7;
    logic [4:0]  rt2;
    logic [4:0]  rt;
    logic [63:0] base;
    logic        ill;
    logic [63:0] a0;
    logic [63:0] a1;
    logic        wbe;
    logic [63:0] wb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd2,1'b0,2'b10,1'b1,7'h02,5'd4, 5'd3, 64'h1000,1'b0,64'h1010,64'h1018,1'b0,64'h0},
    '{2'd0,1'b0,2'b11,1'b0,7'h7D,5'd9, 5'd8, 64'h1000,1'b0,64'h0FF4,64'h0FF8,1'b1,64'h0FF4},
    '{2'd0,1'b0,2'b01,1'b1,7'h05,5'd2, 5'd1, 64'h1000,1'b0,64'h1000,64'h1004,1'b1,64'h1014},
    '{2'd1,1'b0,2'b01,1'b1,7'h01,5'd6, 5'd5, 64'h1000,1'b0,64'h1000,64'h1004,1'b1,64'h1004},
    '{2'd1,1'b0,2'b10,1'b1,7'h01,5'd6, 5'd5, 64'h1000,1'b1,64'h0,64'h0,1'b0,64'h0},
    '{2'd1,1'b0,2'b10,1'b0,7'h01,5'd6, 5'd5, 64'h1000,1'b1,64'h0,64'h0,1'b0,64'h0},
    '{2'd3,1'b0,2'b10,1'b1,7'h01,5'd6, 5'd5, 64'h1000,1'b1,64'h0,64'h0,1'b0,64'h0},
    '{2'd2,1'b1,2'b10,1'b1,7'h01,5'd6, 5'd5, 64'h1000,1'b1,64'h0,64'h0,1'b0,64'h0},
    '{2'd2,1'b0,2'b10,1'b1,7'h00,5'd5, 5'd31,64'h1000,1'b0,64'h1000,64'h1008,1'b0,64'h0},
    '{2'd2,1'b0,2'b00,1'b0,7'h7F,5'd11,5'd10,64'h1000,1'b0,64'h0FF8,64'h1000,1'b0,64'h0},
    '{2'd2,1'b0,2'b10,1'b1,7'h00,5'd4, 5'd3, 64'hFFFF_FFFF_FFFF_FFF8,1'b0,64'hFFFF_FFFF_FFFF_FFF8,64'h0,1'b0,64'h0},
    '{2'd2,1'b0,2'b11,1'b1,7'h7E,5'd13,5'd12,64'h2000,1'b0,64'h1FF0,64'h1FF8,1'b1,64'h1FF0},
    '{2'd1,1'b0,2'b11,1'b1,7'h03,5'd15,5'd14,64'h1000,1'b0,64'h100C,64'h1010,1'b1,64'h100C}
  };

  function automatic logic [31:0] mkInstr(vec_t v);
    return {v.opc, 3'b101, v.vec, 1'b0, v.mode, v.ld, v.imm7, v.rt2, 5'd7, v.rt};
  endfunction

  task automatic checkUop(vec_t v, bit second);
    logic [4:0] r;
    r = second ? v.rt2 : v.rt;
    chk("R1/R2 illegal", outIllegal, v.ill);
    chk("R4 valid", outValid, 1'b1);
    chk("R4 uop index", outUopIdx, second);
    chk("R4 last", outLast, second | v.ill);
    chk("R4 inReady", inReady, second | v.ill);
    chk("R6 base index", baseIdx, 5'd7);
    if (v.ill) begin
      chk("R3 no writeback", outWbEn, 1'b0);
      chk("R3 no dest", outDestWrite, 1'b0);
    end else begin
      chk("R6 address", outAddr, second ? v.a1 : v.a0);
      chk("R8 register", outReg, r);
      chk("R8 dest write", outDestWrite, v.ld && r != 5'd31);
      chk("R5 size", outSizeLog2, {1'b1, v.opc[1]});
      chk("R5 signed", outSigned, v.ld & v.opc[0]);
      chk("R7 wb enable", outWbEn, second & v.wbe);
      if (second && v.wbe) begin
        chk("R7 wb data", outWbData, v.wb);
        chk("R7 wb reg", outWbReg, 5'd7);
      end
    end
  endtask

  initial begin
    outReady = 1'b1;
    inValid = 1'b1;
    inInstr = mkInstr(VECS[0]);
    baseData = VECS[0].base;
    repeat (3) @(negedge clk);
    chk("R11 reset index", outUopIdx, 1'b0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      inInstr = mkInstr(VECS[i]);
      baseData = VECS[i].base;
      inValid = 1'b1;
      #1;
      checkUop(VECS[i], 1'b0);
      @(negedge clk);
      if (!VECS[i].ill) begin
        checkUop(VECS[i], 1'b1);
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    @(negedge clk);

    // R1: non-pair class word
    inInstr = 32'h0;
    inValid = 1'b1;
    #1;
    chk("R1 non-pair illegal", outIllegal, 1'b1);
    chk("R3 single uop last", outLast, 1'b1);
    @(negedge clk);
    chk("R3 index stays 0", outUopIdx, 1'b0);

    // R9: stall on each micro-op
    inInstr = mkInstr(VECS[0]);
    baseData = VECS[0].base;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold uop0 index", outUopIdx, 1'b0);
    chk("R9 hold uop0 addr", outAddr, VECS[0].a0);
    chk("R9 no consume", inReady, 1'b0);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold uop1 index", outUopIdx, 1'b1);
    chk("R9 hold uop1 addr", outAddr, VECS[0].a1);
    chk("R9 no consume uop1", inReady, 1'b0);
    outReady = 1'b1;
    @(negedge clk);
    chk("R4 back to uop0", outUopIdx, 1'b0);

    // R11: reset in the middle of a pair
    inInstr = mkInstr(VECS[1]);
    baseData = VECS[1].base;
    @(negedge clk);
    chk("R11 mid-pair at uop1", outUopIdx, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R11 mid-pair reset", outUopIdx, 1'b0);
    chk("R11 address after reset", outAddr, VECS[1].a0);
    inValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(HALF * 2 * 20000);
    if (!done) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule